// File: doc/BRIEF.md
# Temperature Compensation Trim Controller

This block turns a digital temperature reading into two trim settings for a crystal oscillator: a fine trim in 1 ppm steps and a coarse trim in 30.5 ppm steps. A crystal runs slow by a parabolic amount around its turnover temperature, -α·(T − T0)². The block therefore computes the correction needed, which is the initial fine trim plus α·(T − T0)². It uses a short sequential datapath. It then splits the result into a coarse step count and a fine remainder. Both outputs saturate when the correction is outside their combined reach.

The block holds an 8-bit control register, written through a simple write port. Bit 7 is the master enable. Bits 6:5 choose how often compensation runs while the chip is on battery. Bits 4:0 hold a step-calibration value that is loaded at reset and never changed by a write. Runs are started on a schedule counted in one-second ticks. A run also starts at once when the control register is written with the enable bit set. The temperature is the only input that differs between runs. Each temperature therefore gives exactly one fine/coarse pair.

Top module: `tc_trim_ctrl`

## Requirements
- R1: After reset the control register reads {3'b000, CAL_INIT}, fine and coarse trim are 0, and the done output is low.
- R2: A control write loads bits 7:5 from the write data and leaves bits 4:0 (the step-calibration value) unchanged.
- R3: A control write with bit 7 = 1 starts a run at once, and done is asserted within 32 clock cycles. A write with bit 7 = 0 starts no run.
- R4: On main power (on_battery = 0) with bit 7 = 1, a run starts on every P_MAIN-th second tick counted from the last write or the last scheduled run.
- R5: On battery with bit 7 = 1, bits 6:5 pick the interval: 00 means no scheduled runs, 01 means P_BAT1 ticks, 10 means P_BAT2 ticks, 11 means P_BAT3 ticks.
- R6: With bit 7 = 0, second ticks start no run.
- R7: The correction, in units of 2^-AF ppm, is init_trim·2^AF + α·(T − T0)². The coarse trim is the step count k in -10..+10 that minimises |correction − k·30.5 ppm|. On a tie, the k of smaller magnitude wins.
- R8: The fine trim is the remainder after the coarse steps, rounded to the nearest ppm (halves round up) and clamped to -31..+32.
- R9: Done is a one-cycle pulse. Fine and coarse trim change only in the cycle in which done is high.
- R10: A new trigger during a run restarts the run with the present inputs. That gives one done, carrying the result for the later inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| on_battery | input | 1 | 1 while running from the backup supply |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Present control register value |
| temp_in | input | TEMP_W | Signed temperature sample, °C |
| t0_in | input | TEMP_W | Signed turnover temperature, °C |
| alpha_in | input | ALPHA_W | Unsigned curvature constant, AF fraction bits, ppm/°C² |
| init_trim_in | input | TRIM_W | Signed initial fine trim, ppm |
| fine_trim | output | 7 | Signed final fine trim, ppm |
| coarse_trim | output | 5 | Signed final coarse trim, 30.5 ppm steps |
| trim_done | output | 1 | Pulse when the trims update |

## Verification
The bench builds the block with scheduling intervals of 3 ticks on main power and 2, 4 and 5 ticks for the three battery codes. Every schedule can therefore be seen several times within a short run. It keeps the default datapath widths, with an 8-bit temperature, a 12-bit α and 10 fraction bits. With these, full-scale α and temperature spread drive the correction well past 337 ppm, so saturation of both trims can be reached. Small α values with unit temperature offsets land exactly on the rounding and coarse-tie boundaries.

// File: rtl/tc_pkg.sv
package tc_pkg;

  localparam int FINE_W     = 7;
  localparam int COARSE_W   = 5;
  localparam int FINE_HI    = 32;
  localparam int FINE_LO    = -31;
  localparam int COARSE_LIM = 10;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SQ,
    S_MUL,
    S_SUM,
    S_DIV,
    S_OUT
  } calc_state_t;

  // Round a remainder held with `frac` fraction bits to whole ppm,
  // halves upward, then clamp into the fine trim range.
  function automatic logic signed [FINE_W-1:0] fine_from_rem(input longint rem, input int frac);
    longint q;
    q = (rem + (longint'(1) <<< (frac - 1))) >>> frac;
    if (q > FINE_HI) q = FINE_HI;
    else if (q < FINE_LO) q = FINE_LO;
    return FINE_W'(q);
  endfunction

endpackage

// File: rtl/tc_sched.sv
module tc_sched #(
  parameter int P_MAIN = 60,
  parameter int P_BAT1 = 60,
  parameter int P_BAT2 = 300,
  parameter int P_BAT3 = 600,
  parameter logic [4:0] CAL_INIT = 5'h10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       on_battery,
  input  logic       sec_tick,
  output logic [7:0] ctrl,
  output logic       run_start
);

  localparam int MAX_A = (P_MAIN > P_BAT1) ? P_MAIN : P_BAT1;
  localparam int MAX_B = (P_BAT2 > P_BAT3) ? P_BAT2 : P_BAT3;
  localparam int MAX_P = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_P + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] interval;
  logic             active;
  logic             wr_trig;
  logic             tick_trig;

  always_comb begin
    if (!on_battery) begin
      interval = CNT_W'(P_MAIN);
    end else begin
      case (ctrl[6:5])
        2'b01:   interval = CNT_W'(P_BAT1);
        2'b10:   interval = CNT_W'(P_BAT2);
        2'b11:   interval = CNT_W'(P_BAT3);
        default: interval = CNT_W'(1);
      endcase
    end
  end

  assign active    = ctrl[7] && (!on_battery || (ctrl[6:5] != 2'b00));
  assign wr_trig   = wr_en && wr_data[7];
  assign tick_trig = active && sec_tick && (({1'b0, cnt} + 1'b1) >= {1'b0, interval});
  assign run_start = wr_trig || tick_trig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= {3'b000, CAL_INIT};
      cnt  <= '0;
    end else begin
      if (wr_en) ctrl <= {wr_data[7:5], ctrl[4:0]};
      if (wr_en || !active) cnt <= '0;
      else if (sec_tick) cnt <= tick_trig ? '0 : cnt + 1'b1;
    end
  end

  // R2: the calibration field never moves
  a_r2_cal_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ctrl[4:0]));

  // R6: no run without enable, unless a write sets it
  a_r6_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[7] && !(wr_en && wr_data[7])) |-> !run_start);

  // R5: battery code 00 never schedules
  a_r5_bat_off: assert property (@(posedge clk) disable iff (!rst_n)
    (on_battery && ctrl[6:5] == 2'b00 && !wr_en) |-> !run_start);

  // R4: the counter restarts after each run
  a_r4_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (cnt == '0));

endmodule

// File: rtl/tc_calc.sv
module tc_calc
  import tc_pkg::*;
#(
  parameter int TEMP_W  = 8,
  parameter int ALPHA_W = 12,
  parameter int AF      = 10,
  parameter int TRIM_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic signed [TEMP_W-1:0]   temp,
  input  logic signed [TEMP_W-1:0]   t0,
  input  logic        [ALPHA_W-1:0]  alpha,
  input  logic signed [TRIM_W-1:0]   init_trim,
  output logic signed [FINE_W-1:0]   fine,
  output logic signed [COARSE_W-1:0] coarse,
  output logic                       done
);

  localparam int D_W    = TEMP_W + 1;
  localparam int SQ_W   = 2 * D_W;
  localparam int PROD_W = ALPHA_W + SQ_W;
  localparam int W_A    = (PROD_W > TRIM_W + AF) ? PROD_W : TRIM_W + AF;
  localparam int W_B    = (W_A > AF + 10) ? W_A : AF + 10;
  localparam int TOT_W  = W_B + 2;
  localparam logic signed [TOT_W-1:0]    STEP  = TOT_W'(61) <<< (AF - 1);
  localparam logic signed [TOT_W-1:0]    HALF  = TOT_W'(61) <<< (AF - 2);
  localparam logic signed [COARSE_W-1:0] K_MAX = COARSE_W'(COARSE_LIM);
  localparam logic signed [COARSE_W-1:0] K_MIN = -COARSE_W'(COARSE_LIM);
  localparam logic signed [COARSE_W-1:0] K_ONE = COARSE_W'(1);

  calc_state_t state;
  logic signed [D_W-1:0]      d;
  logic        [SQ_W-1:0]     sq;
  logic        [PROD_W-1:0]   prod;
  logic        [ALPHA_W-1:0]  alpha_q;
  logic signed [TRIM_W-1:0]   init_q;
  logic signed [TOT_W-1:0]    rem;
  logic signed [COARSE_W-1:0] k;

  logic signed [SQ_W-1:0]   d_ext;
  logic        [PROD_W-1:0] a_ext;
  logic        [PROD_W-1:0] sq_ext;
  logic signed [TOT_W-1:0]  init_ext;
  logic signed [TOT_W-1:0]  prod_ext;
  logic                     go_down;
  logic                     go_up;

  assign d_ext    = SQ_W'(d);
  assign a_ext    = PROD_W'(alpha_q);
  assign sq_ext   = PROD_W'(sq);
  assign init_ext = TOT_W'(init_q);
  assign prod_ext = TOT_W'(prod);
  assign go_down  = (rem > HALF) && (k < K_MAX);
  assign go_up    = (rem < -HALF) && (k > K_MIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      d       <= '0;
      sq      <= '0;
      prod    <= '0;
      alpha_q <= '0;
      init_q  <= '0;
      rem     <= '0;
      k       <= '0;
      fine    <= '0;
      coarse  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        d       <= D_W'(temp) - D_W'(t0);
        alpha_q <= alpha;
        init_q  <= init_trim;
        state   <= S_SQ;
      end else begin
        case (state)
          S_SQ: begin
            sq    <= $unsigned(d_ext * d_ext);
            state <= S_MUL;
          end
          S_MUL: begin
            prod  <= a_ext * sq_ext;
            state <= S_SUM;
          end
          S_SUM: begin
            rem   <= (init_ext <<< AF) + prod_ext;
            k     <= '0;
            state <= S_DIV;
          end
          S_DIV: begin
            if (go_down) begin
              rem <= rem - STEP;
              k   <= k + K_ONE;
            end else if (go_up) begin
              rem <= rem + STEP;
              k   <= k - K_ONE;
            end else begin
              state <= S_OUT;
            end
          end
          S_OUT: begin
            fine   <= fine_from_rem(longint'(rem), AF);
            coarse <= k;
            done   <= 1'b1;
            state  <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R9: done lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: trims move only with done
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(fine) && $stable(coarse)));

  // R8: fine trim stays inside its range
  a_r8_fine_range: assert property (@(posedge clk) disable iff (!rst_n)
    (fine >= FINE_W'(FINE_LO)) && (fine <= FINE_W'(FINE_HI)));

  // R7: coarse trim stays inside its range
  a_r7_coarse_range: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse >= K_MIN) && (coarse <= K_MAX));

  // R7: each search step moves the count by one toward the remainder
  a_r7_div_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DIV && !start && go_down) |=> (k == $past(k) + K_ONE));

endmodule

// File: rtl/tc_trim_ctrl.sv
module tc_trim_ctrl #(
  parameter int TEMP_W  = 8,
  parameter int ALPHA_W = 12,
  parameter int AF      = 10,
  parameter int TRIM_W  = 8,
  parameter int P_MAIN  = 60,
  parameter int P_BAT1  = 60,
  parameter int P_BAT2  = 300,
  parameter int P_BAT3  = 600,
  parameter logic [4:0] CAL_INIT = 5'h10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sec_tick,
  input  logic                      on_battery,
  input  logic                      cfg_wr,
  input  logic [7:0]                cfg_wdata,
  output logic [7:0]                cfg_rdata,
  input  logic signed [TEMP_W-1:0]  temp_in,
  input  logic signed [TEMP_W-1:0]  t0_in,
  input  logic [ALPHA_W-1:0]        alpha_in,
  input  logic signed [TRIM_W-1:0]  init_trim_in,
  output logic signed [6:0]         fine_trim,
  output logic signed [4:0]         coarse_trim,
  output logic                      trim_done
);

  logic run_start;

  tc_sched #(
    .P_MAIN(P_MAIN), .P_BAT1(P_BAT1), .P_BAT2(P_BAT2), .P_BAT3(P_BAT3),
    .CAL_INIT(CAL_INIT)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_data(cfg_wdata),
    .on_battery(on_battery), .sec_tick(sec_tick),
    .ctrl(cfg_rdata), .run_start(run_start)
  );

  tc_calc #(
    .TEMP_W(TEMP_W), .ALPHA_W(ALPHA_W), .AF(AF), .TRIM_W(TRIM_W)
  ) u_calc (
    .clk(clk), .rst_n(rst_n), .start(run_start),
    .temp(temp_in), .t0(t0_in), .alpha(alpha_in), .init_trim(init_trim_in),
    .fine(fine_trim), .coarse(coarse_trim), .done(trim_done)
  );

endmodule

// File: tb/sim_tc_trim_ctrl.sv
module sim_tc_trim_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AF = 10;
  localparam int PM = 3, PB1 = 2, PB2 = 4, PB3 = 5;
  localparam logic [4:0] CAL = 5'h15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic on_battery = 1'b0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic signed [7:0] temp_in = '0;
  logic signed [7:0] t0_in = '0;
  logic [11:0] alpha_in = '0;
  logic signed [7:0] init_trim_in = '0;
  logic signed [6:0] fine_trim;
  logic signed [4:0] coarse_trim;
  logic trim_done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tc_trim_ctrl #(
    .TEMP_W(8), .ALPHA_W(12), .AF(AF), .TRIM_W(8),
    .P_MAIN(PM), .P_BAT1(PB1), .P_BAT2(PB2), .P_BAT3(PB3), .CAL_INIT(CAL)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .on_battery(on_battery),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .temp_in(temp_in), .t0_in(t0_in), .alpha_in(alpha_in), .init_trim_in(init_trim_in),
    .fine_trim(fine_trim), .coarse_trim(coarse_trim), .trim_done(trim_done)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=%0d cycles expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Search all coarse counts for the smallest remainder, then round.
  function automatic void model(input int t, input int t0, input int a, input int it,
                                output int ec, output int ef);
    longint tot, r, br, step;
    int bk;
    step = longint'(61) <<< (AF - 1);
    tot = longint'(it) * (longint'(1) <<< AF) + longint'(a) * (t - t0) * (t - t0);
    bk = 0;
    br = tot;
    for (int kk = -10; kk <= 10; kk++) begin
      r = tot - kk * step;
      if (((r < 0) ? -r : r) < ((br < 0) ? -br : br) ||
          (((r < 0) ? -r : r) == ((br < 0) ? -br : br) &&
           ((kk < 0) ? -kk : kk) < ((bk < 0) ? -bk : bk))) begin
        br = r;
        bk = kk;
      end
    end
    ec = bk;
    r = (br + (longint'(1) <<< (AF - 1))) >>> AF;
    if (r > 32) r = 32;
    if (r < -31) r = -31;
    ef = int'(r);
  endfunction

  task automatic wr(input logic [7:0] v);
    cfg_wdata = v;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!trim_done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic tick_count(output int n);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    n = 0;
    for (int i = 0; i < 30; i++) begin
      if (trim_done) n++;
      @(negedge clk);
    end
  endtask

  task automatic run_case(input int t, input int t0, input int a, input int it, input string tag);
    int ec, ef, lat;
    temp_in = 8'(t); t0_in = 8'(t0); alpha_in = 12'(a); init_trim_in = 8'(it);
    model(t, t0, a, it, ec, ef);
    wr(8'h80);
    wait_done(lat);
    chk(lat <= 32, "R3 done latency", lat, 32);
    chk(int'(coarse_trim) == ec, {"R7 coarse ", tag}, coarse_trim, ec);
    chk(int'(fine_trim) == ef, {"R8 fine ", tag}, fine_trim, ef);
    @(negedge clk);
    chk(!trim_done, "R9 done one cycle", trim_done, 0);
  endtask

  task automatic sched_check(input int period, input int nticks, input string req);
    int n;
    logic signed [6:0] f0;
    logic signed [4:0] c0;
    for (int i = 1; i <= nticks; i++) begin
      f0 = fine_trim;
      c0 = coarse_trim;
      tick_count(n);
      if (period == 0) begin
        chk(n == 0, req, n, 0);
        chk(fine_trim == f0 && coarse_trim == c0, "R9 trims held", fine_trim, f0);
      end else begin
        chk(n == ((i % period == 0) ? 1 : 0), req, n, (i % period == 0) ? 1 : 0);
      end
    end
  endtask

  initial begin
    int lat, n, ec, ef;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(cfg_rdata == {3'b000, CAL}, "R1 ctrl", cfg_rdata, {3'b000, CAL});
    chk(fine_trim == 0 && coarse_trim == 0, "R1 trims", fine_trim, 0);
    chk(!trim_done, "R1 done", trim_done, 0);

    // R2 / R3: write with enable clear keeps calibration, starts nothing
    wr(8'h7F);
    chk(cfg_rdata == {3'b011, CAL}, "R2 ctrl write", cfg_rdata, {3'b011, CAL});
    n = 0;
    repeat (40) begin if (trim_done) n++; @(negedge clk); end
    chk(n == 0, "R3 no run without enable", n, 0);

    // R7 / R8 directed corners
    run_case(25, 25, 35, 0, "zero");
    run_case(-128, 127, 4095, 127, "sat high");
    run_case(0, 1, 256, 15, "coarse tie");
    run_case(0, 1, 512, 0, "half round");
    run_case(0, 0, 0, -128, "neg init");
    run_case(85, 25, 35, 3, "hot");
    run_case(-40, 25, 35, -20, "cold");
    wr(8'h9A);
    chk(cfg_rdata == {3'b100, CAL}, "R2 cal kept", cfg_rdata, {3'b100, CAL});
    wait_done(lat);

    // R7 / R8 random
    for (int i = 0; i < 40; i++) begin
      int t, t0, a, it;
      t  = $urandom_range(255) - 128;
      t0 = $urandom_range(40) + 5;
      a  = (i % 4 == 0) ? $urandom_range(4095) : $urandom_range(60);
      it = $urandom_range(80) - 40;
      run_case(t, t0, a, it, "random");
    end

    // R4 main power schedule (last write was an enabling run)
    temp_in = 8'(60); t0_in = 8'(25); alpha_in = 12'(35); init_trim_in = 8'(0);
    wr(8'h80);
    wait_done(lat);
    sched_check(PM, 7, "R4 main period");

    // R5 battery modes
    on_battery = 1'b1;
    wr(8'h80);
    wait_done(lat);
    @(negedge clk);
    sched_check(0, 6, "R5 battery code 00");
    wr(8'hA0); wait_done(lat); @(negedge clk);
    sched_check(PB1, 5, "R5 battery code 01");
    wr(8'hC0); wait_done(lat); @(negedge clk);
    sched_check(PB2, 8, "R5 battery code 10");
    wr(8'hE0); wait_done(lat); @(negedge clk);
    sched_check(PB3, 10, "R5 battery code 11");

    // R6 disabled: no scheduled runs on either supply
    wr(8'h60);
    sched_check(0, 6, "R6 disabled battery");
    on_battery = 1'b0;
    sched_check(0, 6, "R6 disabled main");

    // R10 restart during a run
    temp_in = 8'(25); t0_in = 8'(25); alpha_in = 12'(35); init_trim_in = 8'(0);
    wr(8'h80);
    @(negedge clk);
    temp_in = 8'(85); init_trim_in = 8'(3);
    wr(8'h80);
    n = 0;
    repeat (40) begin if (trim_done) n++; @(negedge clk); end
    model(85, 25, 35, 3, ec, ef);
    chk(n == 1, "R10 single done", n, 1);
    chk(int'(coarse_trim) == ec, "R10 coarse", coarse_trim, ec);
    chk(int'(fine_trim) == ef, "R10 fine", fine_trim, ef);

    summary();
    $finish;
  end

endmodule